// File: doc/BRIEF.md
# Directory Flush Lock Handler

This block is the home-directory controller for a single cache line during a line flush. It takes the flush-specific requests from the request queue: a fetch-for-flush (GETF), a lock request from the current owner (BLOCK) and the final flush writeback (PUTF). It answers each of them on a forward channel toward the caches and, where the line's state needs it, on a memory read channel. While a flush is in progress the line is locked, and every other request is held back in the queue.

The ordinary read and write flows belong to a separate handler. That handler reports the stable state it has reached through an update port. Requests that this block does not own are passed on to it with a one-cycle strobe. The block settles races between a lock request and transactions already under way: it stalls the lock request, drops it, or tolerates a late unblock message, depending on the state the line is in.

Top module: `flh_dir_flush`

## Requirements
- R1: The line state is `line_state`, encoded as 0 home, 1 owned, 2 not-owner-exclusive, 3 not-owner, 4 shared, 5 busy, 6 busy-pending-exclusive, 7 writeback-locked, 8 flush-locked and 9 flush-memory-wait. After the synchronous reset it is 0, and `fwd_valid`, `mem_rd_valid` and `pass_valid` are low.
- R2: Request kinds on `req_kind` are 0 GETS, 1 GETX, 2 PUT, 3 filter-replacement, 4 DMA read, 5 DMA write, 6 GETF, 7 BLOCK and 8 PUTF. A BLOCK in state 2 or 3 is accepted. One cycle later it produces a forward of kind 1 (lock acknowledge) addressed to `req_src`, and the state becomes 8.
- R3: In state 8 every request kind except PUTF is held (`req_ready` low). An unblock in state 8 is consumed and leaves the state at 8.
- R4: A PUTF in state 8 is accepted. One cycle later it produces a forward of kind 2 (writeback acknowledge) to `req_src`, and the state becomes 7.
- R5: In state 7 every request is held, BLOCK included. An unblock moves the state to 0.
- R6: A BLOCK in state 5 or 6 is accepted and dropped: no forward, no memory read, no pass strobe, and no state change.
- R7: A GETF in state 0 raises `mem_rd_valid` for one cycle and moves to state 9. In state 1 it also produces a broadcast probe (forward kind 3) in the same cycle.
- R8: In state 9 every request is held. A memory response sends a forward of kind 5 (data) to the GETF requester recorded on entry, and the state becomes 8.
- R9: A GETF in state 2 or 4 produces a broadcast probe (kind 3) and moves to state 8. In state 3 it produces an owner probe (kind 4) and moves to state 8.
- R10: A GETF or GETX in state 5 is not accepted but moves the state to 6. In state 6 both are held. An unblock in state 5 or 6 moves the state to 3.
- R11: In states 0 to 4, any request the state does not use for a flush is accepted, and `pass_valid` pulses one cycle later. In states 5 and 6, requests other than BLOCK are held.
- R12: A memory response, unblock or state update presented in a cycle keeps `req_ready` low in that cycle. A state update applies only to targets 0 to 6 from states 0 to 6, and is ignored in states 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request queue head valid |
| req_kind | input | 4 | Request kind code |
| req_src | input | SRC_W | Requesting cache id |
| req_ready | output | 1 | Head request accepted this cycle |
| unblk_valid | input | 1 | Unblock message from a cache |
| mem_rsp_valid | input | 1 | Memory data returned |
| ord_upd_valid | input | 1 | State update from the ordinary handler |
| ord_upd_state | input | 4 | Updated state code |
| fwd_valid | output | 1 | Forward message valid (registered) |
| fwd_kind | output | 3 | Forward message kind |
| fwd_dst | output | SRC_W | Requester the forward concerns |
| mem_rd_valid | output | 1 | Memory read request (registered) |
| pass_valid | output | 1 | Request handed to the ordinary handler (registered) |
| line_state | output | 4 | Current line state |

## Verification
The bound properties check on every cycle that requests are held in states 7, 8 and 9, that side events block acceptance, and that an unblock in state 8 leaves the lock in place. They also check the acknowledge-and-transition pairs for BLOCK, PUTF and the memory response, and that a dropped BLOCK leaves no trace. Only the bench scenarios can show the complete flush sequence: the recorded requester identity carried through the memory wait, the return to state 0, and the precedence of side events over a waiting BLOCK.

// File: rtl/flh_pkg.sv
package flh_pkg;

  typedef enum logic [3:0] {
    LS_HOME   = 4'd0,
    LS_OWNED  = 4'd1,
    LS_NOX    = 4'd2,
    LS_NOOWN  = 4'd3,
    LS_SHARED = 4'd4,
    LS_BUSY   = 4'd5,
    LS_BUSYX  = 4'd6,
    LS_WBLK   = 4'd7,
    LS_FLOCK  = 4'd8,
    LS_FMEM   = 4'd9
  } line_st_e;

  typedef enum logic [3:0] {
    RK_GETS   = 4'd0,
    RK_GETX   = 4'd1,
    RK_PUT    = 4'd2,
    RK_PFREPL = 4'd3,
    RK_DMARD  = 4'd4,
    RK_DMAWR  = 4'd5,
    RK_GETF   = 4'd6,
    RK_BLOCK  = 4'd7,
    RK_PUTF   = 4'd8
  } req_kind_e;

  typedef enum logic [2:0] {
    FK_NONE      = 3'd0,
    FK_BLKACK    = 3'd1,
    FK_WBACK     = 3'd2,
    FK_PROBE_ALL = 3'd3,
    FK_PROBE_OWN = 3'd4,
    FK_DATA      = 3'd5
  } fwd_kind_e;

  typedef struct packed {
    logic      fwd;
    fwd_kind_e fkind;
    logic      use_saved;
    logic      mem_rd;
    logic      pass;
  } act_t;

  localparam int unsigned ST_W    = 4;
  localparam int unsigned KIND_W  = 4;
  localparam int unsigned FKIND_W = 3;
  localparam logic [3:0]  UPD_MAX = 4'd6;

endpackage

// File: rtl/flh_decide.sv
module flh_decide
  import flh_pkg::*;
(
  input  line_st_e             cur_st,
  input  logic                 req_valid,
  input  logic [KIND_W-1:0]    req_kind,
  input  logic                 unblk_valid,
  input  logic                 mem_rsp_valid,
  input  logic                 ord_upd_valid,
  input  logic [ST_W-1:0]      ord_upd_state,
  output logic                 req_ready,
  output line_st_e             nxt_st,
  output act_t                 act,
  output logic                 save_src
);

  logic is_getf, is_block, is_putf, is_getx, side_evt, upd_ok;

  always_comb begin
    is_getf  = (req_kind == RK_GETF);
    is_block = (req_kind == RK_BLOCK);
    is_putf  = (req_kind == RK_PUTF);
    is_getx  = (req_kind == RK_GETX);
    side_evt = mem_rsp_valid | unblk_valid | ord_upd_valid;
    upd_ok   = (cur_st <= LS_BUSYX) && (ord_upd_state <= UPD_MAX);
  end

  always_comb begin
    nxt_st    = cur_st;
    act       = '0;
    req_ready = 1'b0;
    save_src  = 1'b0;
    if (mem_rsp_valid) begin
      if (cur_st == LS_FMEM) begin
        nxt_st        = LS_FLOCK;
        act.fwd       = 1'b1;
        act.fkind     = FK_DATA;
        act.use_saved = 1'b1;
      end
    end else if (unblk_valid) begin
      case (cur_st)
        LS_BUSY, LS_BUSYX: nxt_st = LS_NOOWN;
        LS_WBLK:           nxt_st = LS_HOME;
        default:           nxt_st = cur_st;
      endcase
    end else if (ord_upd_valid) begin
      if (upd_ok) nxt_st = line_st_e'(ord_upd_state);
    end else if (req_valid && !side_evt) begin
      case (cur_st)
        LS_HOME: begin
          req_ready = 1'b1;
          if (is_getf) begin
            nxt_st     = LS_FMEM;
            act.mem_rd = 1'b1;
            save_src   = 1'b1;
          end else act.pass = 1'b1;
        end
        LS_OWNED: begin
          req_ready = 1'b1;
          if (is_getf) begin
            nxt_st     = LS_FMEM;
            act.mem_rd = 1'b1;
            act.fwd    = 1'b1;
            act.fkind  = FK_PROBE_ALL;
            save_src   = 1'b1;
          end else act.pass = 1'b1;
        end
        LS_NOX, LS_NOOWN: begin
          req_ready = 1'b1;
          if (is_getf) begin
            nxt_st    = LS_FLOCK;
            act.fwd   = 1'b1;
            act.fkind = (cur_st == LS_NOX) ? FK_PROBE_ALL : FK_PROBE_OWN;
          end else if (is_block) begin
            nxt_st    = LS_FLOCK;
            act.fwd   = 1'b1;
            act.fkind = FK_BLKACK;
          end else act.pass = 1'b1;
        end
        LS_SHARED: begin
          req_ready = 1'b1;
          if (is_getf) begin
            nxt_st    = LS_FLOCK;
            act.fwd   = 1'b1;
            act.fkind = FK_PROBE_ALL;
          end else act.pass = 1'b1;
        end
        LS_BUSY: begin
          if (is_block) req_ready = 1'b1;
          else if (is_getf || is_getx) nxt_st = LS_BUSYX;
        end
        LS_BUSYX: begin
          if (is_block) req_ready = 1'b1;
        end
        LS_FLOCK: begin
          if (is_putf) begin
            req_ready = 1'b1;
            nxt_st    = LS_WBLK;
            act.fwd   = 1'b1;
            act.fkind = FK_WBACK;
          end
        end
        default: req_ready = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/flh_linereg.sv
module flh_linereg
  import flh_pkg::*;
#(
  parameter int unsigned SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  line_st_e         nxt_st,
  input  logic             save_src,
  input  logic [SRC_W-1:0] req_src,
  output line_st_e         cur_st,
  output logic [SRC_W-1:0] saved_src
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_st    <= LS_HOME;
      saved_src <= '0;
    end else begin
      cur_st <= nxt_st;
      if (save_src) saved_src <= req_src;
    end
  end

endmodule

// File: rtl/flh_outreg.sv
module flh_outreg
  import flh_pkg::*;
#(
  parameter int unsigned SRC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  act_t               act,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [SRC_W-1:0]   saved_src,
  output logic               fwd_valid,
  output logic [FKIND_W-1:0] fwd_kind,
  output logic [SRC_W-1:0]   fwd_dst,
  output logic               mem_rd_valid,
  output logic               pass_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid    <= 1'b0;
      fwd_kind     <= '0;
      fwd_dst      <= '0;
      mem_rd_valid <= 1'b0;
      pass_valid   <= 1'b0;
    end else begin
      fwd_valid    <= act.fwd;
      fwd_kind     <= act.fkind;
      fwd_dst      <= act.use_saved ? saved_src : req_src;
      mem_rd_valid <= act.mem_rd;
      pass_valid   <= act.pass;
    end
  end

endmodule

// File: rtl/flh_dir_flush.sv
module flh_dir_flush
  import flh_pkg::*;
#(
  parameter int unsigned SRC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [3:0]         req_kind,
  input  logic [SRC_W-1:0]   req_src,
  output logic               req_ready,
  input  logic               unblk_valid,
  input  logic               mem_rsp_valid,
  input  logic               ord_upd_valid,
  input  logic [3:0]         ord_upd_state,
  output logic               fwd_valid,
  output logic [2:0]         fwd_kind,
  output logic [SRC_W-1:0]   fwd_dst,
  output logic               mem_rd_valid,
  output logic               pass_valid,
  output logic [3:0]         line_state
);

  line_st_e         cur_st, nxt_st;
  act_t             act;
  logic             save_src;
  logic [SRC_W-1:0] saved_src;

  flh_decide u_decide (
    .cur_st        (cur_st),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .unblk_valid   (unblk_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .ord_upd_valid (ord_upd_valid),
    .ord_upd_state (ord_upd_state),
    .req_ready     (req_ready),
    .nxt_st        (nxt_st),
    .act           (act),
    .save_src      (save_src)
  );

  flh_linereg #(.SRC_W(SRC_W)) u_linereg (
    .clk       (clk),
    .rst       (rst),
    .nxt_st    (nxt_st),
    .save_src  (save_src),
    .req_src   (req_src),
    .cur_st    (cur_st),
    .saved_src (saved_src)
  );

  flh_outreg #(.SRC_W(SRC_W)) u_outreg (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .req_src      (req_src),
    .saved_src    (saved_src),
    .fwd_valid    (fwd_valid),
    .fwd_kind     (fwd_kind),
    .fwd_dst      (fwd_dst),
    .mem_rd_valid (mem_rd_valid),
    .pass_valid   (pass_valid)
  );

  assign line_state = cur_st;

endmodule

// File: rtl/flh_dir_flush_chk.sv
module flh_dir_flush_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [3:0] req_kind,
  input logic       req_ready,
  input logic       unblk_valid,
  input logic       mem_rsp_valid,
  input logic       ord_upd_valid,
  input logic       fwd_valid,
  input logic [2:0] fwd_kind,
  input logic       mem_rd_valid,
  input logic       pass_valid,
  input logic [3:0] line_state
);

  a_r2_block_ack: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_kind == 4'd7 && (line_state == 4'd2 || line_state == 4'd3))
    |=> (fwd_valid && fwd_kind == 3'd1 && line_state == 4'd8));

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd8 && req_valid && req_kind != 4'd8) |-> !req_ready);

  a_r3_late_unblock: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd8 && unblk_valid) |=> line_state == 4'd8);

  a_r4_putf_ack: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd8 && req_valid && req_ready && req_kind == 4'd8)
    |=> (fwd_valid && fwd_kind == 3'd2 && line_state == 4'd7));

  a_r5_wb_holds: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd7) |-> !req_ready);

  a_r6_block_drop: assert property (@(posedge clk) disable iff (rst)
    ((line_state == 4'd5 || line_state == 4'd6) && req_valid && req_ready)
    |=> (!fwd_valid && !mem_rd_valid && !pass_valid && $stable(line_state)));

  a_r8_mem_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd9) |-> !req_ready);

  a_r8_data_out: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd9 && mem_rsp_valid)
    |=> (fwd_valid && fwd_kind == 3'd5 && line_state == 4'd8));

  a_r11_pass_alone: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> !(fwd_valid || mem_rd_valid));

  a_r12_side_first: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid || unblk_valid || ord_upd_valid) |-> !req_ready);

endmodule

bind flh_dir_flush flh_dir_flush_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .req_ready     (req_ready),
  .unblk_valid   (unblk_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .ord_upd_valid (ord_upd_valid),
  .fwd_valid     (fwd_valid),
  .fwd_kind      (fwd_kind),
  .mem_rd_valid  (mem_rd_valid),
  .pass_valid    (pass_valid),
  .line_state    (line_state)
);

// File: tb/test_flh_dir_flush.sv
`timescale 1ns/1ps
module test_flh_dir_flush;

  localparam int unsigned SRC_W = 3;

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] st0;
    logic [3:0] kind;
    logic       rdy;
    logic [3:0] st1;
    logic       fv;
    logic [2:0] fk;
    logic       mr;
    logic       pass;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd7,  4'd0, 4'd6, 1'b1, 4'd9, 1'b0, 3'd0, 1'b1, 1'b0},  // R7 home GETF
    '{4'd7,  4'd1, 4'd6, 1'b1, 4'd9, 1'b1, 3'd3, 1'b1, 1'b0},  // R7 owned GETF
    '{4'd2,  4'd2, 4'd7, 1'b1, 4'd8, 1'b1, 3'd1, 1'b0, 1'b0},  // R2 BLOCK nox
    '{4'd2,  4'd3, 4'd7, 1'b1, 4'd8, 1'b1, 3'd1, 1'b0, 1'b0},  // R2 BLOCK noown
    '{4'd9,  4'd2, 4'd6, 1'b1, 4'd8, 1'b1, 3'd3, 1'b0, 1'b0},  // R9
    '{4'd9,  4'd4, 4'd6, 1'b1, 4'd8, 1'b1, 3'd3, 1'b0, 1'b0},  // R9
    '{4'd9,  4'd3, 4'd6, 1'b1, 4'd8, 1'b1, 3'd4, 1'b0, 1'b0},  // R9
    '{4'd6,  4'd5, 4'd7, 1'b1, 4'd5, 1'b0, 3'd0, 1'b0, 1'b0},  // R6
    '{4'd6,  4'd6, 4'd7, 1'b1, 4'd6, 1'b0, 3'd0, 1'b0, 1'b0},  // R6
    '{4'd10, 4'd5, 4'd6, 1'b0, 4'd6, 1'b0, 3'd0, 1'b0, 1'b0},  // R10
    '{4'd10, 4'd5, 4'd1, 1'b0, 4'd6, 1'b0, 3'd0, 1'b0, 1'b0},  // R10
    '{4'd10, 4'd6, 4'd6, 1'b0, 4'd6, 1'b0, 3'd0, 1'b0, 1'b0},  // R10
    '{4'd11, 4'd0, 4'd0, 1'b1, 4'd0, 1'b0, 3'd0, 1'b0, 1'b1},  // R11
    '{4'd11, 4'd4, 4'd7, 1'b1, 4'd4, 1'b0, 3'd0, 1'b0, 1'b1},  // R11
    '{4'd11, 4'd5, 4'd0, 1'b0, 4'd5, 1'b0, 3'd0, 1'b0, 1'b0},  // R11
    '{4'd11, 4'd0, 4'd8, 1'b1, 4'd0, 1'b0, 3'd0, 1'b0, 1'b1}   // R11
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [3:0]       req_kind = '0;
  logic [SRC_W-1:0] req_src = '0;
  logic             req_ready;
  logic             unblk_valid = 1'b0;
  logic             mem_rsp_valid = 1'b0;
  logic             ord_upd_valid = 1'b0;
  logic [3:0]       ord_upd_state = '0;
  logic             fwd_valid;
  logic [2:0]       fwd_kind;
  logic [SRC_W-1:0] fwd_dst;
  logic             mem_rd_valid;
  logic             pass_valid;
  logic [3:0]       line_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flh_dir_flush #(.SRC_W(SRC_W)) i_flh_dir_flush (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_ready(req_ready), .unblk_valid(unblk_valid),
    .mem_rsp_valid(mem_rsp_valid), .ord_upd_valid(ord_upd_valid),
    .ord_upd_state(ord_upd_state), .fwd_valid(fwd_valid), .fwd_kind(fwd_kind),
    .fwd_dst(fwd_dst), .mem_rd_valid(mem_rd_valid), .pass_valid(pass_valid),
    .line_state(line_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = 1'b0; unblk_valid = 1'b0; mem_rsp_valid = 1'b0; ord_upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; clear_in();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_req(input logic [3:0] k, input logic [SRC_W-1:0] s);
    req_valid = 1'b1; req_kind = k; req_src = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", line_state, 0);
    chk("R1 fwd", fwd_valid, 0);
    chk("R1 memrd", mem_rd_valid, 0);
    chk("R1 pass", pass_valid, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      ord_upd_valid = 1'b1; ord_upd_state = VECS[i].st0;
      @(negedge clk);
      ord_upd_valid = 1'b0;
      put_req(VECS[i].kind, 3'd5);
      #1;
      chk($sformatf("R%0d vec%0d ready", VECS[i].req, i), req_ready, VECS[i].rdy);
      @(negedge clk);
      clear_in();
      chk($sformatf("R%0d vec%0d state", VECS[i].req, i), line_state, VECS[i].st1);
      chk($sformatf("R%0d vec%0d fwd", VECS[i].req, i), fwd_valid, VECS[i].fv);
      if (VECS[i].fv) begin
        chk($sformatf("R%0d vec%0d fkind", VECS[i].req, i), fwd_kind, VECS[i].fk);
        chk($sformatf("R%0d vec%0d dst", VECS[i].req, i), fwd_dst, 5);
      end
      chk($sformatf("R%0d vec%0d memrd", VECS[i].req, i), mem_rd_valid, VECS[i].mr);
      chk($sformatf("R%0d vec%0d pass", VECS[i].req, i), pass_valid, VECS[i].pass);
    end

    // Full flush walk: R7, R8, R12, R3, R4, R5
    do_reset();
    put_req(4'd6, 3'd2);
    @(negedge clk); clear_in();
    chk("R7 enter wait", line_state, 9);
    put_req(4'd7, 3'd4); #1;
    chk("R8 hold BLOCK", req_ready, 0);
    req_kind = 4'd4; #1;
    chk("R8 hold DMA read", req_ready, 0);
    req_valid = 1'b0;
    ord_upd_valid = 1'b1; ord_upd_state = 4'd2;
    @(negedge clk); clear_in();
    chk("R12 update ignored in wait", line_state, 9);
    mem_rsp_valid = 1'b1;
    @(negedge clk); clear_in();
    chk("R8 data fwd", fwd_valid, 1);
    chk("R8 data kind", fwd_kind, 5);
    chk("R8 data dst saved", fwd_dst, 2);
    chk("R8 to lock", line_state, 8);
    put_req(4'd0, 3'd1); #1;
    chk("R3 GETS held", req_ready, 0);
    req_kind = 4'd7; #1;
    chk("R3 BLOCK held", req_ready, 0);
    req_valid = 1'b0; unblk_valid = 1'b1;
    @(negedge clk); clear_in();
    chk("R3 unblock keeps lock", line_state, 8);
    put_req(4'd8, 3'd6); #1;
    chk("R4 PUTF ready", req_ready, 1);
    @(negedge clk); clear_in();
    chk("R4 wback kind", fwd_kind, 2);
    chk("R4 wback dst", fwd_dst, 6);
    chk("R4 to wb", line_state, 7);
    put_req(4'd7, 3'd1); #1;
    chk("R5 BLOCK held in wb", req_ready, 0);
    req_valid = 1'b0; unblk_valid = 1'b1;
    @(negedge clk); clear_in();
    chk("R5 unblock home", line_state, 0);

    // R12 side event blocks a waiting BLOCK
    do_reset();
    ord_upd_valid = 1'b1; ord_upd_state = 4'd2;
    @(negedge clk); clear_in();
    put_req(4'd7, 3'd3); unblk_valid = 1'b1; #1;
    chk("R12 unblock first", req_ready, 0);
    @(negedge clk); clear_in();
    chk("R12 no ack", fwd_valid, 0);
    chk("R12 state kept", line_state, 2);

    // R10 unblock from busy
    do_reset();
    ord_upd_valid = 1'b1; ord_upd_state = 4'd5;
    @(negedge clk); clear_in();
    unblk_valid = 1'b1;
    @(negedge clk); clear_in();
    chk("R10 busy unblock", line_state, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule